// File: doc/BRIEF.md
# Two-Lane Bitwise Equivalence and Sign-Extension Unit

This unit executes three two-lane vector operations for a wider execution pipeline. Each cycle it may accept a 32-bit instruction word and two 64-bit source operands, called A and B. It decodes the instruction's opcode fields and returns a registered 64-bit result one cycle later.

A 64-bit operand holds two independent 32-bit lanes. The operations are:

- **Equivalence:** the bitwise complement of the XOR of A and B.
- **Byte sign-extension:** the lowest byte of each lane of A, sign-extended to 32 bits.
- **Halfword sign-extension:** the lowest halfword of each lane of A, sign-extended to 32 bits.

Any other encoding is reported as illegal and gives a zero result. The unit keeps no status state, and it does not read or write the register file.

Bit numbering follows the big-endian convention of the instruction format, where bit 0 is the most significant bit. Instruction bit k is therefore `insn_i[31-k]`. Operand bits 0:31 (the high lane) sit in `[63:32]`.

Top module: `simd_lse_unit`

## Requirements
- R1: The primary opcode is `insn_i[31:26]` (format bits 0:5) and must equal 4. The extended opcode is `insn_i[10:0]` (format bits 21:31). The value 537 selects equivalence, 522 selects byte sign-extension and 523 selects halfword sign-extension.
- R2: For equivalence, each 32-bit lane of the result equals the complement of (A lane XOR B lane).
- R3: For byte sign-extension, `result_o[63:32]` is `src_a_i[39:32]` sign-extended, and `result_o[31:0]` is `src_a_i[7:0]` sign-extended.
- R4: For halfword sign-extension, `result_o[63:32]` is `src_a_i[47:32]` sign-extended, and `result_o[31:0]` is `src_a_i[15:0]` sign-extended.
- R5: The two lanes are computed independently. In one result, one lane can be sign-filled with ones while the other is filled with zeros.
- R6: The sign-extension forms ignore `src_b_i` and the register-number fields (`insn_i[25:11]`), including the reserved B field. Any value of these gives the same result.
- R7: An instruction whose primary opcode is not 4, or whose extended opcode is not one of the three listed, gives `illegal_o` = 1 and `result_o` = 0 together with `valid_o`.
- R8: `valid_o` equals `valid_i` delayed by exactly one clock. `illegal_o` is 0 whenever `valid_o` is 0.
- R9: In a cycle with `valid_i` low, `result_o` keeps its previous value.
- R10: While `rst_ni` is low, `valid_o`, `illegal_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 64 | First source operand, two 32-bit lanes |
| src_b_i | input | 64 | Second source operand, two 32-bit lanes |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| illegal_o | output | 1 | Instruction not supported |
| result_o | output | 64 | Registered two-lane result |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the two lanes of one result receiving opposite sign fills. The vector table provokes this with operands whose high lane has its sign bit set and whose low lane has it clear, and the reverse. Both halves of the result are then compared against values worked out by hand.

The second pair is an illegal instruction completing in the same cycle that a legal one is accepted. The table is streamed back to back, one entry per cycle, so illegal entries sit directly between legal ones. Each output cycle is judged on its flag, and an illegal result must be zero even when the previous result was not.

// File: rtl/simd_lse_pkg.sv
package simd_lse_pkg;
  localparam int INSN_W    = 32;
  localparam int LANE_W    = 32;
  localparam int NUM_LANES = 2;
  localparam int DATA_W    = LANE_W * NUM_LANES;
  localparam int BYTE_W    = 8;
  localparam int HALF_W    = 16;
  localparam int PO_W      = 6;
  localparam int XO_W      = 11;

  localparam logic [PO_W-1:0] PO_VEC  = 6'd4;
  localparam logic [XO_W-1:0] XO_EQV  = 11'd537;
  localparam logic [XO_W-1:0] XO_SXB  = 11'd522;
  localparam logic [XO_W-1:0] XO_SXH  = 11'd523;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_EQV  = 2'd1,
    OP_SXB  = 2'd2,
    OP_SXH  = 2'd3
  } op_e;
endpackage

// File: rtl/simd_lse_decode.sv
module simd_lse_decode
  import simd_lse_pkg::*;
#(
  parameter int IW = INSN_W
) (
  input  logic [IW-1:0] insn_i,
  output op_e           op_o,
  output logic          illegal_o
);
  logic [PO_W-1:0] po;
  logic [XO_W-1:0] xo;

  // big-endian bits 0:5 are the top of the word, bits 21:31 the bottom
  assign po = insn_i[IW-1 -: PO_W];
  assign xo = insn_i[XO_W-1:0];

  always_comb begin
    op_o = OP_NONE;
    if (po == PO_VEC) begin
      unique case (xo)
        XO_EQV:  op_o = OP_EQV;
        XO_SXB:  op_o = OP_SXB;
        XO_SXH:  op_o = OP_SXH;
        default: op_o = OP_NONE;
      endcase
    end
  end

  assign illegal_o = (op_o == OP_NONE);
endmodule

// File: rtl/simd_lse_lane.sv
module simd_lse_lane
  import simd_lse_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int BW = BYTE_W,
  parameter int HW = HALF_W
) (
  input  op_e           op_i,
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic [LW-1:0] res_o
);
  localparam int BFILL = LW - BW;
  localparam int HFILL = LW - HW;

  logic [LW-1:0] eqv_res, sxb_res, sxh_res;

  assign eqv_res = ~(a_i ^ b_i);
  assign sxb_res = {{BFILL{a_i[BW-1]}}, a_i[BW-1:0]};
  assign sxh_res = {{HFILL{a_i[HW-1]}}, a_i[HW-1:0]};

  always_comb begin
    unique case (op_i)
      OP_EQV:  res_o = eqv_res;
      OP_SXB:  res_o = sxb_res;
      OP_SXH:  res_o = sxh_res;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_lse_unit.sv
module simd_lse_unit
  import simd_lse_pkg::*;
#(
  parameter int IW = INSN_W,
  parameter int LW = LANE_W,
  parameter int NL = NUM_LANES,
  localparam int DW = LW * NL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [IW-1:0] insn_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  output logic          valid_o,
  output logic          illegal_o,
  output logic [DW-1:0] result_o
);
  op_e           op;
  logic          dec_illegal;
  logic [DW-1:0] lane_res;
  logic          valid_q, illegal_q;
  logic [DW-1:0] result_q;

  simd_lse_decode #(.IW(IW)) u_dec (
    .insn_i    (insn_i),
    .op_o      (op),
    .illegal_o (dec_illegal)
  );

  // lane NL-1 occupies the top bits: element 0 in big-endian numbering
  for (genvar l = 0; l < NL; l++) begin : g_lane
    simd_lse_lane #(.LW(LW), .BW(BYTE_W), .HW(HALF_W)) u_lane (
      .op_i  (op),
      .a_i   (src_a_i[l*LW +: LW]),
      .b_i   (src_b_i[l*LW +: LW]),
      .res_o (lane_res[l*LW +: LW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q   <= valid_i;
      illegal_q <= valid_i & dec_illegal;
      if (valid_i) result_q <= dec_illegal ? '0 : lane_res;
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
  assign result_o  = result_q;
endmodule

// File: rtl/simd_lse_unit_chk.sv
module simd_lse_unit_chk
  import simd_lse_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic              valid_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] result_o
);
  logic po_ok, is_eqv, is_sxb;
  assign po_ok  = insn_i[INSN_W-1 -: PO_W] == PO_VEC;
  assign is_eqv = po_ok && insn_i[XO_W-1:0] == XO_EQV;
  assign is_sxb = po_ok && insn_i[XO_W-1:0] == XO_SXB;

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !illegal_o));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_illegal_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && result_o == '0));
  assert_bad_primary_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !po_ok) |=> illegal_o);
  assert_eqv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_eqv) |=> (!illegal_o && result_o == ~($past(src_a_i) ^ $past(src_b_i))));
  assert_sxb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_sxb) |=> (result_o ==
      {{(LANE_W-BYTE_W){$past(src_a_i[LANE_W+BYTE_W-1])}}, $past(src_a_i[LANE_W +: BYTE_W]),
       {(LANE_W-BYTE_W){$past(src_a_i[BYTE_W-1])}}, $past(src_a_i[BYTE_W-1:0])}));
endmodule

bind simd_lse_unit simd_lse_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .result_o  (result_o)
);

// File: tb/tb_simd_lse_unit.sv
module tb_simd_lse_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  simd_lse_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  // primary opcode in [31:26], fields RT=1 RA=2 RB=3, extended opcode in [10:0]
  function automatic logic [31:0] mk(input logic [5:0] po, input logic [10:0] xo);
    return {po, 5'd1, 5'd2, 5'd3, xo};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{mk(6'd4, 11'd537), 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b0},
    '{mk(6'd4, 11'd537), '1, '1, 64'hFFFFFFFF_FFFFFFFF, 1'b0},
    '{mk(6'd4, 11'd537), '1, 64'h0, 64'h0, 1'b0},
    '{mk(6'd4, 11'd537), 64'h01234567_89ABCDEF, 64'h0F0F0F0F_F0F0F0F0, 64'hF1D3B597_86A4C2E0, 1'b0},
    '{mk(6'd4, 11'd522), 64'h00000080_0000007F, 64'hDEADBEEF_CAFEF00D, 64'hFFFFFF80_0000007F, 1'b0},
    '{mk(6'd5, 11'd537), 64'h12345678_12345678, 64'h0, 64'h0, 1'b1},
    '{mk(6'd4, 11'd522), 64'h1234567F_ABCDEF80, 64'hFFFFFFFF_FFFFFFFF, 64'h0000007F_FFFFFF80, 1'b0},
    '{mk(6'd4, 11'd524), 64'h1, 64'h2, 64'h0, 1'b1},
    '{mk(6'd4, 11'd523), 64'h00008000_00007FFF, 64'h55555555_AAAAAAAA, 64'hFFFF8000_00007FFF, 1'b0},
    '{mk(6'd4, 11'd536), 64'h0, 64'h0, 64'h0, 1'b1},
    '{mk(6'd4, 11'd523), 64'hDEAD1234_0000FFFF, 64'h0, 64'h00001234_FFFFFFFF, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    // R10 reset state
    repeat (2) @(negedge clk_i);
    check("R10 valid", {63'b0, valid_o}, 64'd0);
    check("R10 illegal", {63'b0, illegal_o}, 64'd0);
    check("R10 result", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // streamed table: one entry per cycle (R1-style decode, R2..R7)
    valid_i = 1'b1;
    insn_i = VECS[0].insn; src_a_i = VECS[0].a; src_b_i = VECS[0].b;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      check("R8 valid_o after valid_i", {63'b0, valid_o}, 64'd1);
      check("R7 R1 illegal flag", {63'b0, illegal_o}, {63'b0, VECS[i].ill});
      check("R2 R3 R4 R5 R6 R7 result", result_o, VECS[i].exp);
      if (i + 1 < NV) begin
        insn_i = VECS[i+1].insn; src_a_i = VECS[i+1].a; src_b_i = VECS[i+1].b;
      end
    end

    // R6: same sign-extend with different B data and register fields
    insn_i = {6'd4, 5'd31, 5'd17, 5'd29, 11'd522};
    src_a_i = 64'h00000080_0000007F; src_b_i = 64'h0;
    @(negedge clk_i);
    check("R6 fields ignored", result_o, 64'hFFFFFF80_0000007F);

    // R9/R8: valid low holds result, clears valid and illegal
    held = result_o;
    valid_i = 1'b0;
    insn_i = mk(6'd4, 11'd537); src_a_i = '1; src_b_i = 64'h0;
    @(negedge clk_i);
    check("R8 valid_o low", {63'b0, valid_o}, 64'd0);
    check("R9 result held", result_o, held);
    insn_i = mk(6'd0, 11'd0);
    @(negedge clk_i);
    check("R8 illegal_o low when idle", {63'b0, illegal_o}, 64'd0);
    check("R9 result still held", result_o, held);

    // R1: ext opcode 537 with wrong primary opcode 36 (bit 0 set)
    valid_i = 1'b1; insn_i = mk(6'd36, 11'd537); src_a_i = '1; src_b_i = '1;
    @(negedge clk_i);
    check("R1 primary opcode", {63'b0, illegal_o}, 64'd1);
    check("R7 zero result", result_o, 64'd0);

    // R10: asynchronous reset mid-run
    insn_i = mk(6'd4, 11'd537); src_a_i = 64'h0; src_b_i = 64'h0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R10 async result", result_o, 64'd0);
    check("R10 async valid", {63'b0, valid_o}, 64'd0);
    valid_i = 1'b0;
    @(negedge clk_i);
    finish_run();
  end
endmodule